// File: doc/BRIEF.md
# Multiplexed Parallel Register Port

This block is the slave side of a host register port built on one 8-bit bus that carries both addresses and data. Three control pins frame each byte. An active-low chip select marks the byte. A read/write pin is high for a read. An address/data pin is high for an address byte. Each byte is taken, or handed over, on a falling edge of chip select. The pins are brought into the system clock domain through a synchronizer, and a registered edge detect on chip select gives a one-cycle byte strobe.

Every access moves one 16-bit register as two bytes, upper byte first. A transaction opens with an address byte. Its low five bits pick one of 32 registers, bit 7 asks for auto-configuration, and bits 6 and 5 carry no meaning. Two write bytes then form a new register value. For a read, the block presents the upper byte and then the lower byte. The whole register array is exposed as one flat vector, together with a bus output-enable and a one-clock auto-configure pulse.

Top module: `mux_reg_port`

## Requirements
- R1: Synchronous active-high reset clears all 32 registers to zero, parks the byte pointer on the upper byte, clears the output byte to zero and holds the auto-configure pulse low.
- R2: `bus_oe` is high exactly while `rd_wr` is 1 and `cs_n` is 0. It is low while `cs_n` is 1, and low for any byte with `rd_wr` 0.
- R3: A byte strobed with `rd_wr`=0 and `addr_data`=1 is an address byte. Its bits 4:0 select the register, and its bits 6:5 do not affect which register is accessed.
- R4: A byte strobed with `rd_wr`=0 and `addr_data`=0 is write data. The first such byte is the upper half (bits 15:8) and the second is the lower half (bits 7:0). The register changes only after the lower byte, never after the upper byte alone.
- R5: A byte strobed with `rd_wr`=1 and `addr_data`=0 is a read. Before the first such chip-select low after an address byte, `bus_out` holds bits 15:8 of the addressed register. Before the second, it holds bits 7:0. `bus_out` does not change while the synchronized chip select is low.
- R6: An address byte with bit 7 set gives exactly one clock of `autocfg_pulse`. An address byte with bit 7 clear gives none.
- R7: An address byte always sends the byte pointer back to the upper byte. A half-finished write is dropped, and the register it targeted keeps its value.
- R8: After a full byte pair, the pointer returns to the upper byte and the address is kept, so a further pair goes to the same register.
- R9: A byte strobed with `rd_wr`=1 and `addr_data`=1 is ignored: the address and the pointer stay as they were.
- R10: `regs_flat[i*16 +: 16]` holds register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; its falling edge strobes a byte |
| rd_wr | input | 1 | 1 = read byte, 0 = write byte |
| addr_data | input | 1 | 1 = address byte, 0 = data byte |
| bus_in | input | 8 | Byte from the host bus |
| bus_out | output | 8 | Byte presented to the host bus |
| bus_oe | output | 1 | Output enable for the bus driver |
| autocfg_pulse | output | 1 | One-clock pulse for an address byte with bit 7 set |
| regs_flat | output | 512 | All 32 registers, register i at bits i*16+15 : i*16 |

## Verification
The hardest state to reach from the ports is a byte pointer left sitting on the lower half, either by a lone upper write byte or by a lone upper read byte, just before a new address byte or an ignored byte. The bench gets there on purpose. It sends a single upper write byte and then a fresh address byte, and checks that the first target register is unchanged and that the next pair lands whole at the new address. It also streams four write bytes back to back to show that the pointer wraps, and puts a read-address byte between an address byte and its reads.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int AFIELD_W = 5;
  localparam int ACFG_BIT = 7;

  typedef enum logic [1:0] {
    BK_NONE,
    BK_ADDR,
    BK_WDATA,
    BK_RDATA
  } byte_kind_e;

  // Role of a strobed byte, taken from the synchronized control pins
  function automatic byte_kind_e classify(input logic rw, input logic ad);
    if (!rw && ad)  return BK_ADDR;
    if (!rw && !ad) return BK_WDATA;
    if (rw && !ad)  return BK_RDATA;
    return BK_NONE;
  endfunction

  function automatic logic [AFIELD_W-1:0] addr_field(input logic [BYTE_W-1:0] b);
    return b[AFIELD_W-1:0];
  endfunction

  function automatic logic acfg_flag(input logic [BYTE_W-1:0] b);
    return b[ACFG_BIT];
  endfunction

  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic lower);
    return lower ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction
endpackage

// File: rtl/mrp_sync.sv
module mrp_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/mrp_seq.sv
module mrp_seq
  import mrp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              rw_s,
  input  logic              ad_s,
  input  logic              cs_s,
  input  logic [BYTE_W-1:0] din,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              acfg_pulse,
  output logic              addr_stb,
  output logic              byte_ptr,
  output logic [BYTE_W-1:0] dout
);
  byte_kind_e          kind;
  logic [BYTE_W-1:0]   hi_hold;
  logic [AFIELD_W-1:0] a_full;

  assign kind     = stb ? classify(rw_s, ad_s) : BK_NONE;
  assign addr_stb = (kind == BK_ADDR);
  assign a_full   = addr_field(din);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr   <= '0;
      byte_ptr   <= 1'b0;
      hi_hold    <= '0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
      acfg_pulse <= 1'b0;
      dout       <= '0;
    end else begin
      wr_en      <= 1'b0;
      acfg_pulse <= 1'b0;
      case (kind)
        BK_ADDR: begin
          cur_addr   <= a_full[ADDR_W-1:0];
          byte_ptr   <= 1'b0;
          acfg_pulse <= acfg_flag(din);
        end
        BK_WDATA: begin
          if (!byte_ptr) begin
            hi_hold <= din;
          end else begin
            wr_en   <= 1'b1;
            wr_data <= join_bytes(hi_hold, din);
          end
          byte_ptr <= ~byte_ptr;
        end
        BK_RDATA: byte_ptr <= ~byte_ptr;
        default: ;
      endcase
      // the next byte is staged only while chip select is idle, then frozen
      if (cs_s) dout <= pick_byte(rd_word, byte_ptr);
    end
  end
endmodule

// File: rtl/mrp_regfile.sv
module mrp_regfile
  import mrp_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 5,
  localparam int FLAT_W  = NUM_REGS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_word,
  output logic [FLAT_W-1:0] regs_flat
);
  logic [WORD_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_en && (int'(addr) < NUM_REGS)) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_word = (int'(addr) < NUM_REGS) ? mem[addr] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*WORD_W +: WORD_W] = mem[g];
  end
endmodule

// File: rtl/mux_reg_port.sv
module mux_reg_port
  import mrp_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       rd_wr,
  input  logic                       addr_data,
  input  logic [BYTE_W-1:0]          bus_in,
  output logic [BYTE_W-1:0]          bus_out,
  output logic                       bus_oe,
  output logic                       autocfg_pulse,
  output logic [NUM_REGS*WORD_W-1:0] regs_flat
);
  logic              cs_s, rw_s, ad_s, cs_prev, cs_fall_stb;
  logic              addr_stb, byte_ptr, wr_en;
  logic [ADDR_W-1:0] cur_addr;
  logic [WORD_W-1:0] wr_data, rd_word;

  mrp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, rd_wr, addr_data}),
    .q   ({cs_s, rw_s, ad_s})
  );

  always_ff @(posedge clk) begin
    if (rst) cs_prev <= 1'b1;
    else     cs_prev <= cs_s;
  end

  assign cs_fall_stb = cs_prev & ~cs_s;

  mrp_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .stb        (cs_fall_stb),
    .rw_s       (rw_s),
    .ad_s       (ad_s),
    .cs_s       (cs_s),
    .din        (bus_in),
    .rd_word    (rd_word),
    .cur_addr   (cur_addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .acfg_pulse (autocfg_pulse),
    .addr_stb   (addr_stb),
    .byte_ptr   (byte_ptr),
    .dout       (bus_out)
  );

  mrp_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (cur_addr),
    .wr_data   (wr_data),
    .rd_word   (rd_word),
    .regs_flat (regs_flat)
  );

  // the pad driver follows the raw pins, not the synchronized copies
  assign bus_oe = rd_wr & ~cs_n;
endmodule

// File: rtl/mux_reg_port_chk.sv
module mux_reg_port_chk #(
  parameter int FLAT_W = 512,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_wr,
  input logic              bus_oe,
  input logic              autocfg_pulse,
  input logic              addr_stb,
  input logic              wr_en,
  input logic              byte_ptr,
  input logic              cs_s,
  input logic [BYTE_W-1:0] bus_out,
  input logic [FLAT_W-1:0] regs_flat
);
  assert_idle_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !bus_oe);

  assert_write_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_wr |-> !bus_oe);

  assert_reg_change_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(regs_flat) |-> $past(wr_en));

  assert_out_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(cs_s) |-> $stable(bus_out));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    autocfg_pulse |=> !autocfg_pulse);

  assert_pulse_source_R6: assert property (@(posedge clk) disable iff (rst)
    autocfg_pulse |-> $past(addr_stb));

  assert_ptr_restart_R7: assert property (@(posedge clk) disable iff (rst)
    addr_stb |=> !byte_ptr);
endmodule

bind mux_reg_port mux_reg_port_chk #(
  .FLAT_W (NUM_REGS * mrp_pkg::WORD_W),
  .BYTE_W (mrp_pkg::BYTE_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cs_n          (cs_n),
  .rd_wr         (rd_wr),
  .bus_oe        (bus_oe),
  .autocfg_pulse (autocfg_pulse),
  .addr_stb      (addr_stb),
  .wr_en         (wr_en),
  .byte_ptr      (byte_ptr),
  .cs_s          (cs_s),
  .bus_out       (bus_out),
  .regs_flat     (regs_flat)
);

// File: tb/mux_reg_port_test.sv
module mux_reg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cs_n = 1'b1;
  logic             rd_wr = 1'b0;
  logic             addr_data = 1'b0;
  logic [7:0]       bus_in = 8'h00;
  logic [7:0]       bus_out;
  logic             bus_oe;
  logic             autocfg_pulse;
  logic [NREG*16-1:0] regs_flat;

  int n_chk = 0;
  int n_err = 0;
  int pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_reg_port uut (
    .clk           (clk),
    .rst           (rst),
    .cs_n          (cs_n),
    .rd_wr         (rd_wr),
    .addr_data     (addr_data),
    .bus_in        (bus_in),
    .bus_out       (bus_out),
    .bus_oe        (bus_oe),
    .autocfg_pulse (autocfg_pulse),
    .regs_flat     (regs_flat)
  );

  always @(posedge clk) if (!rst && autocfg_pulse) pulses++;

  // {address byte for the write, 16-bit value, address byte for the read}
  localparam logic [31:0] VEC [6] = '{
    {8'h03, 16'hA55A, 8'h03},
    {8'h7F, 16'h1234, 8'h1F},
    {8'h45, 16'hBEEF, 8'h05},
    {8'h0A, 16'h00FF, 8'h6A},
    {8'h10, 16'hFF00, 8'h10},
    {8'h01, 16'h8001, 8'h21}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_of(input int a);
    return regs_flat[a*16 +: 16];
  endfunction

  // One byte with chip select low; returns bus_out and bus_oe sampled early
  // and late in the low phase
  task automatic xfer(input logic rw, input logic ad, input logic [7:0] d,
                      output logic [7:0] q1, output logic [7:0] q2, output logic oe);
    @(negedge clk);
    rd_wr = rw; addr_data = ad; bus_in = d;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    q1 = bus_out; oe = bus_oe;
    repeat (2) @(negedge clk);
    q2 = bus_out;
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic put(input logic ad, input logic [7:0] d);
    logic [7:0] a, b; logic oe;
    xfer(1'b0, ad, d, a, b, oe);
    chk("R2 write byte leaves bus undriven", {31'd0, oe}, 32'd0);
  endtask

  task automatic get(output logic [7:0] q);
    logic [7:0] b; logic oe;
    xfer(1'b1, 1'b0, 8'h00, q, b, oe);
    chk("R2 read byte drives bus", {31'd0, oe}, 32'd1);
    chk("R5 output steady while selected", {24'd0, b}, {24'd0, q});
  endtask

  initial begin
    logic [7:0] hi, lo;
    int pbase;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 all registers zero", {31'd0, (regs_flat == '0)}, 32'd1);
    chk("R1 output byte zero", {24'd0, bus_out}, 32'd0);
    chk("R1 no pulse", pulses, 0);
    rd_wr = 1'b1; #1;
    chk("R2 undriven while deselected", {31'd0, bus_oe}, 32'd0);
    rd_wr = 1'b0;

    // table of write then read-back transactions (R3, R4, R5, R10)
    for (int i = 0; i < 6; i++) begin
      logic [7:0] wa, ra; logic [15:0] val;
      {wa, val, ra} = VEC[i];
      put(1'b1, wa);
      put(1'b0, val[15:8]);
      put(1'b0, val[7:0]);
      chk("R10 flat slice holds value", {16'd0, reg_of(int'(wa[4:0]))}, {16'd0, val});
      put(1'b1, ra);
      get(hi);
      get(lo);
      chk("R5 upper byte first", {24'd0, hi}, {24'd0, val[15:8]});
      chk("R3 R5 lower byte second", {24'd0, lo}, {24'd0, val[7:0]});
    end
    chk("R6 no pulse without bit 7", pulses, 0);

    // R6 auto-configure flag
    pbase = pulses;
    put(1'b1, 8'h8C);
    chk("R6 one pulse for bit 7", pulses, pbase + 1);
    put(1'b1, 8'h0C);
    chk("R6 no pulse for clear bit 7", pulses, pbase + 1);

    // R4 upper byte alone changes nothing
    put(1'b1, 8'h02);
    put(1'b0, 8'h77);
    chk("R4 no update after upper byte", {16'd0, reg_of(2)}, 32'd0);
    put(1'b0, 8'h88);
    chk("R4 update after lower byte", {16'd0, reg_of(2)}, 32'h7788);

    // R7 new address abandons half write
    put(1'b1, 8'h04);
    put(1'b0, 8'h11);
    put(1'b1, 8'h06);
    put(1'b0, 8'h22);
    put(1'b0, 8'h33);
    chk("R7 abandoned target unchanged", {16'd0, reg_of(4)}, 32'd0);
    chk("R7 new pair lands whole", {16'd0, reg_of(6)}, 32'h2233);

    // R8 pointer wraps, address kept
    put(1'b1, 8'h08);
    put(1'b0, 8'hAA);
    put(1'b0, 8'hBB);
    chk("R8 first pair", {16'd0, reg_of(8)}, 32'hAABB);
    put(1'b0, 8'hCC);
    put(1'b0, 8'hDD);
    chk("R8 second pair same register", {16'd0, reg_of(8)}, 32'hCCDD);

    // R7 read pointer restart: one upper read, then address byte
    put(1'b1, 8'h02);
    get(hi);
    put(1'b1, 8'h08);
    get(hi);
    get(lo);
    chk("R7 read restarts at upper", {16'd0, hi, lo}, 32'hCCDD);

    // R9 byte with rw=1 and ad=1 is ignored
    put(1'b1, 8'h06);
    begin
      logic [7:0] a, b; logic oe;
      xfer(1'b1, 1'b1, 8'h08, a, b, oe);
    end
    get(hi);
    get(lo);
    chk("R9 address kept after ignored byte", {16'd0, hi, lo}, 32'h2233);

    // R1 reset again clears the array
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 registers cleared by reset", {31'd0, (regs_flat == '0)}, 32'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule